// File: doc/BRIEF.md
# Ethernet Transmit Deferral and Status Control

This block decides when a 10 Mb/s Ethernet MAC may begin a transmission and raises two per-frame status flags after each frame: lost carrier and missing collision heartbeat. It watches the MAC's own transmit activity, the carrier and collision indications from the attachment, and a bit-time tick. From these it times the inter-packet gap and, in half-duplex mode, the blinding window that follows each transmission. It also evaluates the heartbeat test that runs inside that window.

Duplex mode and the active port each change the behaviour. In half-duplex mode, carrier defers transmission, the gap starts only when both transmit and carrier are quiet, and the heartbeat test runs. In full-duplex mode, carrier no longer defers, the gap starts as soon as the previous transmit ends, the blinding window and heartbeat test are gone, and collision is ignored. Status reporting in full-duplex mode is limited to the twisted-pair port while its link is failing.

All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake. The MAC samples `tx_permit` before raising `tx_active`. Both flags hold until the next frame starts.

Top module: `eth_tx_defer_ctl`

## Requirements
- R1: `tx_permit` is low in every cycle where `tx_active` is high. In half-duplex mode it is also low in every cycle where `rx_carrier` is high outside the blinding window.
- R2: The gap counter advances only on cycles with `bit_tick` high and is cleared while deferral is in force. `tx_permit` rises in the cycle after the IPG_BITS-th (default 96) tick counted since deferral ended.
- R3: In full-duplex mode (`full_duplex`=1), `rx_carrier` never defers transmission, and the gap starts at the clock edge where `tx_active` is first seen low.
- R4: In half-duplex mode, the gap starts only once `tx_active` and an unblinded `rx_carrier` are both low. Carrier that persists past the blinding window restarts the gap from zero.
- R5: In half-duplex mode, a blinding window opens at the edge where `tx_active` is first seen low and lasts for BLIND_BITS further ticks (default 40). During the window `rx_carrier` does not defer.
- R6: In half-duplex mode, `heartbeat_err` is set when the blinding window closes if `collision` was not high in any cycle of that window. Otherwise it stays low.
- R7: In half-duplex mode, `carrier_lost` is set at the end of a frame if `rx_carrier` was low in every cycle of `tx_active`. The port and `link_fail` are ignored for both flags.
- R8: In full-duplex mode there is no blinding window and no heartbeat test, and `collision` has no effect on `tx_permit` or either flag.
- R9: Port codes on `port_sel` are 2'b00 AUI, 2'b01 twisted pair, 2'b10 serial, and 2'b11 reserved, which acts as serial. In full-duplex mode with any code other than twisted pair, neither flag is ever set.
- R10: In full-duplex mode with twisted pair selected, both flags are set at the end of a frame if `link_fail` was high in any cycle of `tx_active`. Otherwise both stay low.
- R11: Both flags clear at the clock edge where `tx_active` is first seen high.
- R12: After reset, `tx_permit`, `carrier_lost` and `heartbeat_err` are low, and a full gap must elapse before `tx_permit` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_active | input | 1 | MAC is transmitting a frame |
| rx_carrier | input | 1 | Carrier or receive activity on the medium |
| collision | input | 1 | Collision / heartbeat indication from the attachment |
| port_sel | input | 2 | Active port code (see R9) |
| link_fail | input | 1 | Twisted-pair link is in the fail state |
| full_duplex | input | 1 | 1 selects full-duplex behaviour |
| tx_permit | output | 1 | A new transmission may start |
| carrier_lost | output | 1 | Lost-carrier status for the last frame |
| heartbeat_err | output | 1 | Missing-heartbeat status for the last frame |

## Verification
A gap counter off by one shows as `tx_permit` rising a tick early or late after the release, and a bench that compares tick counts catches it within the first gap. A blinding window that is too short, too long or left open in full-duplex mode shows in two places. `tx_permit` falls while a trailing carrier is still meant to be ignored, and `heartbeat_err` follows a collision pulse placed inside the window wrongly. Both appear about 40 ticks after the frame ends. Wrong tracking of carrier or link state during a frame shows only through the flags. It is visible one cycle after `tx_active` falls, which is why every combination of duplex, port, link, carrier and collision is swept.

// File: rtl/txd_pkg.sv
package txd_pkg;
  typedef enum logic [1:0] {
    PORT_AUI = 2'b00,
    PORT_TP  = 2'b01,
    PORT_SER = 2'b10,
    PORT_RSV = 2'b11
  } port_e;
endpackage

// File: rtl/txd_gap_timer.sv
module txd_gap_timer #(
  parameter int IPG_BITS = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic busy,
  output logic gap_done
);
  localparam int CW = $clog2(IPG_BITS + 1);
  localparam logic [CW-1:0] FULL = CW'(IPG_BITS);

  logic [CW-1:0] cnt;

  // Cleared while the medium or the MAC is busy, saturates at the gap length.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (busy) begin
      cnt <= '0;
    end else if (tick && cnt != FULL) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign gap_done = (cnt == FULL);
endmodule

// File: rtl/txd_blind_window.sv
module txd_blind_window #(
  parameter int BLIND_BITS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fd_mode,
  input  logic tx_start,
  input  logic tx_end,
  output logic blind_on,
  output logic win_last
);
  localparam int BW = $clog2(BLIND_BITS + 1);
  localparam logic [BW-1:0] FULL = BW'(BLIND_BITS);

  logic [BW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (fd_mode || tx_start) begin
      cnt <= '0;
    end else if (tx_end) begin
      cnt <= FULL;
    end else if (tick && cnt != '0) begin
      cnt <= cnt - BW'(1);
    end
  end

  // The end cycle itself is already blinded so a looped-back carrier tail
  // does not hold the gap counter for one extra cycle.
  assign blind_on = !fd_mode && ((cnt != '0) || tx_end);
  assign win_last = !fd_mode && !tx_start && tick && (cnt == BW'(1));
endmodule

// File: rtl/txd_status.sv
module txd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic fd_mode,
  input  logic is_tp,
  input  logic tx_active,
  input  logic tx_start,
  input  logic tx_end,
  input  logic carrier,
  input  logic coll,
  input  logic link_bad,
  input  logic blind_on,
  input  logic win_last,
  output logic carrier_lost,
  output logic heartbeat_err
);
  logic crs_seen;
  logic lf_seen;
  logic col_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carrier_lost  <= 1'b0;
      heartbeat_err <= 1'b0;
      crs_seen      <= 1'b0;
      lf_seen       <= 1'b0;
      col_seen      <= 1'b0;
    end else if (tx_start) begin
      carrier_lost  <= 1'b0;
      heartbeat_err <= 1'b0;
      crs_seen      <= carrier;
      lf_seen       <= link_bad;
      col_seen      <= 1'b0;
    end else begin
      if (tx_active) begin
        crs_seen <= crs_seen | carrier;
        lf_seen  <= lf_seen | link_bad;
      end
      if (tx_end) begin
        if (fd_mode) begin
          carrier_lost  <= is_tp & lf_seen;
          heartbeat_err <= is_tp & lf_seen;
          col_seen      <= 1'b0;
        end else begin
          carrier_lost <= !crs_seen;
          col_seen     <= coll;
        end
      end else if (blind_on && coll) begin
        col_seen <= 1'b1;
      end
      if (win_last) begin
        heartbeat_err <= !(col_seen | coll);
      end
    end
  end
endmodule

// File: rtl/eth_tx_defer_ctl.sv
module eth_tx_defer_ctl #(
  parameter int IPG_BITS   = 96,
  parameter int BLIND_BITS = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       tx_active,
  input  logic       rx_carrier,
  input  logic       collision,
  input  logic [1:0] port_sel,
  input  logic       link_fail,
  input  logic       full_duplex,
  output logic       tx_permit,
  output logic       carrier_lost,
  output logic       heartbeat_err
);
  import txd_pkg::*;

  logic tx_d;
  logic tx_start;
  logic tx_end;
  logic blind_on;
  logic win_last;
  logic busy;
  logic gap_done;
  logic is_tp;

  always_ff @(posedge clk) begin
    if (!rst_n) tx_d <= 1'b0;
    else        tx_d <= tx_active;
  end

  assign tx_start = tx_active & ~tx_d;
  assign tx_end   = ~tx_active & tx_d;
  assign is_tp    = (port_sel == PORT_TP);

  // Half duplex: an unblinded carrier defers. Full duplex: only own transmit.
  assign busy = tx_active | (~full_duplex & rx_carrier & ~blind_on);

  txd_blind_window #(.BLIND_BITS(BLIND_BITS)) u_blind (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (bit_tick),
    .fd_mode  (full_duplex),
    .tx_start (tx_start),
    .tx_end   (tx_end),
    .blind_on (blind_on),
    .win_last (win_last)
  );

  txd_gap_timer #(.IPG_BITS(IPG_BITS)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (bit_tick),
    .busy     (busy),
    .gap_done (gap_done)
  );

  txd_status u_stat (
    .clk           (clk),
    .rst_n         (rst_n),
    .fd_mode       (full_duplex),
    .is_tp         (is_tp),
    .tx_active     (tx_active),
    .tx_start      (tx_start),
    .tx_end        (tx_end),
    .carrier       (rx_carrier),
    .coll          (collision),
    .link_bad      (link_fail),
    .blind_on      (blind_on),
    .win_last      (win_last),
    .carrier_lost  (carrier_lost),
    .heartbeat_err (heartbeat_err)
  );

  assign tx_permit = gap_done & ~busy;
endmodule

// File: rtl/eth_tx_defer_chk.sv
module eth_tx_defer_chk #(
  parameter int IPG_BITS = 96
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       tx_active,
  input logic       rx_carrier,
  input logic [1:0] port_sel,
  input logic       full_duplex,
  input logic       blind_on,
  input logic       tx_permit,
  input logic       carrier_lost,
  input logic       heartbeat_err
);
  localparam int CW = $clog2(IPG_BITS + 2);
  localparam logic [CW-1:0] FULL = CW'(IPG_BITS);

  logic [CW-1:0] quiet_ticks;
  logic          tx_q;
  logic          chk_busy;

  assign chk_busy = tx_active | (!full_duplex && rx_carrier && !blind_on);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet_ticks <= '0;
      tx_q        <= 1'b0;
    end else begin
      tx_q <= tx_active;
      if (chk_busy) quiet_ticks <= '0;
      else if (bit_tick && quiet_ticks < FULL) quiet_ticks <= quiet_ticks + CW'(1);
    end
  end

  p_tx_blocks_permit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |-> !tx_permit);

  p_hd_carrier_defers_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex && rx_carrier && !blind_on) |-> !tx_permit);

  p_gap_elapsed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_permit |-> (quiet_ticks == FULL));

  p_fd_quiet_ports_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && port_sel != 2'b01 && tx_q && !tx_active)
      |=> (!carrier_lost && !heartbeat_err));

  p_clear_on_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !tx_q) |=> (!carrier_lost && !heartbeat_err));
endmodule

bind eth_tx_defer_ctl eth_tx_defer_chk #(.IPG_BITS(IPG_BITS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bit_tick      (bit_tick),
  .tx_active     (tx_active),
  .rx_carrier    (rx_carrier),
  .port_sel      (port_sel),
  .full_duplex   (full_duplex),
  .blind_on      (blind_on),
  .tx_permit     (tx_permit),
  .carrier_lost  (carrier_lost),
  .heartbeat_err (heartbeat_err)
);

// File: tb/eth_tx_defer_ctl_tb.sv
`timescale 1ns/1ps
module eth_tx_defer_ctl_tb;
  localparam int IPG   = 96;
  localparam int BLIND = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       tx_active = 1'b0;
  logic       rx_carrier = 1'b0;
  logic       collision = 1'b0;
  logic [1:0] port_sel = 2'b00;
  logic       link_fail = 1'b0;
  logic       full_duplex = 1'b0;
  logic       tx_permit;
  logic       carrier_lost;
  logic       heartbeat_err;

  int checks = 0;
  int errors = 0;
  int tdiv = 1;
  int phase = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    phase = (phase + 1) % tdiv;
    bit_tick <= (phase == 0);
  end

  eth_tx_defer_ctl #(.IPG_BITS(IPG), .BLIND_BITS(BLIND)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_active(tx_active),
    .rx_carrier(rx_carrier), .collision(collision), .port_sel(port_sel),
    .link_fail(link_fail), .full_duplex(full_duplex), .tx_permit(tx_permit),
    .carrier_lost(carrier_lost), .heartbeat_err(heartbeat_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts ticks from the current point; optionally drops carrier after
  // carrier_hold cycles. Returns the number of cycles in which tx_permit
  // disagreed with (ticks >= IPG), plus the tick count when permit first rose.
  task automatic measure_gap(input string req, input int carrier_hold);
    int ticks = 0;
    int cyc = 0;
    int bad = 0;
    int rise_at = -1;
    while (ticks < IPG + 2 && cyc < 2000) begin
      @(posedge clk);
      if (bit_tick) ticks++;
      cyc++;
      #1;
      if (tx_permit !== (ticks >= IPG)) bad++;
      if (tx_permit && rise_at < 0) rise_at = ticks;
      if (cyc == carrier_hold) rx_carrier = 1'b0;
    end
    check({req, " permit mismatches"}, bad, 0);
    check({req, " rise tick"}, rise_at, IPG);
  endtask

  task automatic send_tx(input int len);
    @(negedge clk) tx_active = 1'b1;
    repeat (len) @(negedge clk);
    tx_active = 1'b0;
  endtask

  task automatic sweep_frame(input bit fd, input bit [1:0] ps, input bit lf,
                             input bit crs_on, input bit col_on);
    int exp_l;
    int exp_h;
    string tag;
    tag = $sformatf("fd=%0d port=%0d lf=%0d crs=%0d col=%0d", fd, ps, lf, crs_on, col_on);
    @(negedge clk);
    full_duplex = fd; port_sel = ps; link_fail = lf; rx_carrier = crs_on;
    tx_active = 1'b1;
    @(negedge clk);
    check({"R11 cleared at start ", tag, " lost"}, carrier_lost, 0);
    check({"R11 cleared at start ", tag, " hb"}, heartbeat_err, 0);
    repeat (3) @(negedge clk);
    tx_active = 1'b0; rx_carrier = 1'b0;
    repeat (2) @(negedge clk);
    collision = col_on;
    @(negedge clk) collision = 1'b0;
    repeat (50) @(negedge clk);
    link_fail = 1'b0;
    if (!fd) begin
      exp_l = !crs_on;
      exp_h = !col_on;
    end else begin
      exp_l = (ps == 2'b01) && lf;
      exp_h = exp_l;
    end
    // R6 R7 half duplex, R8 R9 R10 full duplex
    check({fd ? "R9/R10 " : "R7 ", tag, " carrier_lost"}, carrier_lost, exp_l);
    check({fd ? "R8/R10 " : "R6 ", tag, " heartbeat_err"}, heartbeat_err, exp_h);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 permit in reset", tx_permit, 0);
    check("R12 lost in reset", carrier_lost, 0);
    check("R12 hb in reset", heartbeat_err, 0);
    @(negedge clk) rst_n = 1'b1;
    measure_gap("R12 R2 gap after reset", -1);

    // R1: own transmit blocks
    @(negedge clk) tx_active = 1'b1;
    @(negedge clk);
    check("R1 permit during tx", tx_permit, 0);
    tx_active = 1'b0;
    measure_gap("R2 HD gap from tx end", -1);

    // R1: unblinded carrier in HD defers at once; R3: not in FD
    @(negedge clk) rx_carrier = 1'b1;
    #1 check("R1 HD carrier defers", tx_permit, 0);
    @(negedge clk) rx_carrier = 1'b0; full_duplex = 1'b1;
    measure_gap("R3 FD regain gap", -1);
    @(negedge clk) rx_carrier = 1'b1;
    #1 check("R3 FD carrier no defer", tx_permit, 1);
    // R3: gap from tx end with carrier held high throughout
    send_tx(5);
    measure_gap("R3 FD gap from tx end", -1);
    @(negedge clk) rx_carrier = 1'b0;
    // R8: collision ignored in FD for permit
    collision = 1'b1;
    #1 check("R8 FD collision no defer", tx_permit, 1);
    @(negedge clk) collision = 1'b0; full_duplex = 1'b0;

    // R5: HD carrier tail inside blinding window is ignored
    @(negedge clk) rx_carrier = 1'b1; tx_active = 1'b1;
    repeat (4) @(negedge clk);
    tx_active = 1'b0;
    measure_gap("R5 blinded tail", 10);

    // R4: HD carrier persisting beyond the window restarts the gap
    @(negedge clk) rx_carrier = 1'b1; tx_active = 1'b1;
    repeat (4) @(negedge clk);
    tx_active = 1'b0;
    repeat (BLIND + 20) @(negedge clk);
    check("R4 carrier past window defers", tx_permit, 0);
    rx_carrier = 1'b0;
    measure_gap("R4 gap from carrier end", -1);

    // R2: slower tick, ticks counted not cycles
    tdiv = 3;
    send_tx(4);
    measure_gap("R2 tick every third cycle", -1);
    tdiv = 1;

    // Sweep of modes, ports, link, carrier and collision
    for (int f = 0; f < 2; f++)
      for (int p = 0; p < 4; p++)
        for (int l = 0; l < 2; l++)
          for (int c = 0; c < 2; c++)
            for (int k = 0; k < 2; k++)
              sweep_frame(f[0], p[1:0], l[0], c[0], k[0]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule